// File: doc/BRIEF.md
# Converter Operating Mode Controller

This block holds the operating state of a precision digital-to-analog converter and the four registers that the host reaches over the serial link: a 16-bit command word, a 16-bit input code, a 24-bit offset correction word and a 24-bit full-scale correction word. The serial front end hands it whole-register writes. From the mode field of the command word the block decides whether the converter sleeps, wakes up, converts, or runs a self-calibration. It drives the analog output enable, a write lock back to the serial interface, and capture strobes for the correction registers.

The analog measurement engine is not part of this block. The controller tells it which calibration phase is running (offset first, then gain). The engine answers with a done pulse and a result bus for each phase. When the gain phase finishes, the controller sets the mode field back to normal without any host write. Leaving sleep for any other mode passes through a fixed power-up interval, and the output stays dark for all of it.

Command word fields used here: bits [1:0] mode (00 normal, 01 self-calibrate, 10 sleep, 11 reserved and run as normal), bit 2 data format, bit 3 output connect during calibration, bit 4 clear input code, bit 5 clear correction words. Bits 4 and 5 act on write and always read back as 0. Bits [15:6] are stored as written for use elsewhere.

Top module: `conv_mode_ctrl`

## Requirements
- R1: After reset the command word reads 0x0002 (sleep), the input code and both correction words read 0, and out_en, wr_lock and waking are all 0.
- R2: In sleep (mode 10), out_en is 0 and host writes to all four registers (host_sel 00 input code, 01 command, 10 offset, 11 full scale) still take effect at the write edge.
- R3: A write that moves the mode from 10 to any other value raises waking for exactly WAKE_CYC cycles starting one cycle after the write. out_en stays 0 during that interval, and the controller then enters the written mode.
- R4: When the mode field becomes 01, wr_lock is 1 in the next cycle. From normal operation, cal_ofs_run rises one clock after the write.
- R5: While wr_lock is 1, host writes to any register are refused and the registers keep their values.
- R6: The offset phase runs before the gain phase. gain_done is ignored during the offset phase. On ofs_done the offset word captures ofs_result with its top bit inverted (two's complement to offset binary), and the gain phase begins.
- R7: On gain_done during the gain phase, the full-scale word captures fs_result unchanged. In the same edge the mode field returns to 00 with the other command bits kept, wr_lock falls, and normal operation resumes.
- R8: During either calibration phase, out_en equals command bit 3.
- R9: A command write with bit 4 set clears the input code to 0, and bit 4 reads back as 0.
- R10: A command write with bit 5 set clears both correction words to 0, and bit 5 reads back as 0.
- R11: Mode 11 is stored and reads back as 11, but it behaves as normal operation: out_en is 1 and wr_lock is 0.
- R12: ofs_done and gain_done have no effect outside their own calibration phase.
- R13: Writing mode 10 during normal operation sets out_en to 0 one clock after the write, with no wake interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Whole-register write strobe from the serial interface |
| host_sel | input | 2 | Register select: 00 input code, 01 command, 10 offset, 11 full scale |
| host_wdata | input | CAL_W | Write data, low bits used for 16-bit registers |
| ofs_done | input | 1 | Offset measurement finished |
| ofs_result | input | CAL_W | Offset measurement, two's complement |
| gain_done | input | 1 | Gain measurement finished |
| fs_result | input | CAL_W | Gain measurement, unsigned |
| cmd_q | output | CMD_W | Command word |
| data_q | output | DATA_W | Input code register |
| ofs_q | output | CAL_W | Offset correction word |
| fs_q | output | CAL_W | Full-scale correction word |
| out_en | output | 1 | Analog output connect |
| wr_lock | output | 1 | Host writes refused |
| waking | output | 1 | Power-up interval in progress |
| cal_ofs_run | output | 1 | Offset calibration phase active |
| cal_gain_run | output | 1 | Gain calibration phase active |
| cal_ofs_ld | output | 1 | Offset word captures this clock |
| cal_fs_ld | output | 1 | Full-scale word captures this clock |

## Verification
If the sequencer lands in the wrong state, out_en or the phase outputs disagree with the mode field one clock after the edge where the state was entered. A wake counter that is off by one moves the rise of out_en by a cycle, so the bench samples both ends of the interval. A lock that releases too early shows up as a changed register right after a refused write. A missed mode clear leaves wr_lock high and the mode field at 01 after gain_done. The bench checks for this on the very next cycle.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_SLEEP,
    ST_WAKE,
    ST_NORM,
    ST_CAL_OFS,
    ST_CAL_GAIN
  } cmc_state_e;

  // mode field codes, bits [1:0] of the command word
  localparam logic [1:0] MODE_NORM  = 2'b00;
  localparam logic [1:0] MODE_CAL   = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;

  // command word bit positions
  localparam int unsigned BIT_DF     = 2;
  localparam int unsigned BIT_CALPIN = 3;
  localparam int unsigned BIT_CLR    = 4;
  localparam int unsigned BIT_CRST   = 5;

  // host register select
  localparam logic [1:0] SEL_DATA = 2'b00;
  localparam logic [1:0] SEL_CMD  = 2'b01;
  localparam logic [1:0] SEL_OFS  = 2'b10;
  localparam logic [1:0] SEL_FS   = 2'b11;

endpackage

// File: rtl/cmc_seq.sv
module cmc_seq
  import cmc_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_bits,
  input  logic       ofs_done,
  input  logic       gain_done,
  output cmc_state_e state_o,
  output logic       waking,
  output logic       ofs_cap,
  output logic       fs_cap,
  output logic       cal_ofs_run,
  output logic       cal_gain_run
);

  localparam int unsigned CNT_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

  cmc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:   state_d = ST_SLEEP;
      ST_SLEEP: if (mode_bits != MODE_SLEEP) state_d = ST_WAKE;
      ST_WAKE: begin
        if (mode_bits == MODE_SLEEP)
          state_d = ST_SLEEP;
        else if (cnt_q == CNT_LAST)
          state_d = (mode_bits == MODE_CAL) ? ST_CAL_OFS : ST_NORM;
      end
      ST_NORM: begin
        if (mode_bits == MODE_SLEEP)    state_d = ST_SLEEP;
        else if (mode_bits == MODE_CAL) state_d = ST_CAL_OFS;
      end
      ST_CAL_OFS:  if (ofs_done)  state_d = ST_CAL_GAIN;
      ST_CAL_GAIN: if (gain_done) state_d = ST_NORM;
      default:     state_d = ST_SLEEP;
    endcase
  end

  // wake interval counter
  always_comb begin
    cnt_en = (state_q == ST_WAKE) || (state_d == ST_WAKE);
    cnt_d  = (state_q == ST_WAKE) ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_POR;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o      = state_q;
  assign waking       = (state_q == ST_WAKE);
  assign cal_ofs_run  = (state_q == ST_CAL_OFS);
  assign cal_gain_run = (state_q == ST_CAL_GAIN);
  assign ofs_cap      = cal_ofs_run && ofs_done;
  assign fs_cap       = cal_gain_run && gain_done;

  // R6: the gain phase only follows an offset phase
  a_r6_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_gain_run) |-> $past(cal_ofs_run));

  // R12: done pulses in normal operation leave the sequencer in place
  a_r12_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORM && mode_bits[0] == 1'b0 && mode_bits[1] == 1'b0)
      |=> !cal_gain_run);

endmodule

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMD_W  = 16,
  parameter int unsigned CAL_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [CAL_W-1:0]  host_wdata,
  input  logic              ofs_cap,
  input  logic              fs_cap,
  input  logic [CAL_W-1:0]  ofs_result,
  input  logic [CAL_W-1:0]  fs_result,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [CAL_W-1:0]  ofs_q,
  output logic [CAL_W-1:0]  fs_q,
  output logic              wr_lock
);

  localparam logic [CMD_W-1:0] CMD_RST   = CMD_W'(MODE_SLEEP);
  localparam logic [CMD_W-1:0] PULSE_MSK = ~((CMD_W'(1) << BIT_CLR) | (CMD_W'(1) << BIT_CRST));

  logic              wr_ok, wr_cmd, do_clr, do_crst;
  logic              cmd_en, data_en, ofs_en, fs_en;
  logic [CMD_W-1:0]  cmd_d;
  logic [DATA_W-1:0] data_d;
  logic [CAL_W-1:0]  ofs_d, fs_d;

  assign wr_lock = (cmd_q[1:0] == MODE_CAL);
  assign wr_ok   = host_wr && !wr_lock;
  assign wr_cmd  = wr_ok && (host_sel == SEL_CMD);
  assign do_clr  = wr_cmd && host_wdata[BIT_CLR];
  assign do_crst = wr_cmd && host_wdata[BIT_CRST];

  always_comb begin
    cmd_en = fs_cap || wr_cmd;
    if (fs_cap) cmd_d = {cmd_q[CMD_W-1:2], MODE_NORM};
    else        cmd_d = host_wdata[CMD_W-1:0] & PULSE_MSK;
  end

  always_comb begin
    data_en = do_clr || (wr_ok && host_sel == SEL_DATA);
    data_d  = do_clr ? '0 : host_wdata[DATA_W-1:0];
  end

  always_comb begin
    ofs_en = ofs_cap || do_crst || (wr_ok && host_sel == SEL_OFS);
    if (ofs_cap)      ofs_d = {~ofs_result[CAL_W-1], ofs_result[CAL_W-2:0]};
    else if (do_crst) ofs_d = '0;
    else              ofs_d = host_wdata;
  end

  always_comb begin
    fs_en = fs_cap || do_crst || (wr_ok && host_sel == SEL_FS);
    if (fs_cap)       fs_d = fs_result;
    else if (do_crst) fs_d = '0;
    else              fs_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= CMD_RST;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fs_q <= '0;
    else if (fs_en) fs_q <= fs_d;
  end

  // R9: clear request empties the input code and does not stick
  a_r9_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !wr_lock && host_sel == SEL_CMD && host_wdata[BIT_CLR])
      |=> (data_q == '0) && !cmd_q[BIT_CLR]);

  // R10: correction reset empties both words and does not stick
  a_r10_crst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !wr_lock && host_sel == SEL_CMD && host_wdata[BIT_CRST])
      |=> (ofs_q == '0) && (fs_q == '0) && !cmd_q[BIT_CRST]);

endmodule

// File: rtl/cmc_outen.sv
module cmc_outen
  import cmc_pkg::*;
(
  input  cmc_state_e state,
  input  logic       calpin,
  output logic       out_en
);

  always_comb begin
    unique case (state)
      ST_NORM:                 out_en = 1'b1;
      ST_CAL_OFS, ST_CAL_GAIN: out_en = calpin;
      default:                 out_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CMD_W    = 16,
  parameter int unsigned CAL_W    = 24,
  parameter int unsigned WAKE_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [CAL_W-1:0]  host_wdata,
  input  logic              ofs_done,
  input  logic [CAL_W-1:0]  ofs_result,
  input  logic              gain_done,
  input  logic [CAL_W-1:0]  fs_result,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [CAL_W-1:0]  ofs_q,
  output logic [CAL_W-1:0]  fs_q,
  output logic              out_en,
  output logic              wr_lock,
  output logic              waking,
  output logic              cal_ofs_run,
  output logic              cal_gain_run,
  output logic              cal_ofs_ld,
  output logic              cal_fs_ld
);

  cmc_state_e state;

  cmc_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_bits    (cmd_q[1:0]),
    .ofs_done     (ofs_done),
    .gain_done    (gain_done),
    .state_o      (state),
    .waking       (waking),
    .ofs_cap      (cal_ofs_ld),
    .fs_cap       (cal_fs_ld),
    .cal_ofs_run  (cal_ofs_run),
    .cal_gain_run (cal_gain_run)
  );

  cmc_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W), .CAL_W(CAL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .ofs_cap    (cal_ofs_ld),
    .fs_cap     (cal_fs_ld),
    .ofs_result (ofs_result),
    .fs_result  (fs_result),
    .cmd_q      (cmd_q),
    .data_q     (data_q),
    .ofs_q      (ofs_q),
    .fs_q       (fs_q),
    .wr_lock    (wr_lock)
  );

  cmc_outen u_outen (
    .state  (state),
    .calpin (cmd_q[BIT_CALPIN]),
    .out_en (out_en)
  );

  // R3: output stays dark through the power-up interval
  a_r3_wake_dark: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> !out_en);

  // R4: a running calibration always holds the write lock
  a_r4_lock_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_ofs_run || cal_gain_run) |-> wr_lock);

  // R5: a refused write leaves the input code untouched
  a_r5_locked_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && host_wr) |=> $stable(data_q));

  // R7: end of gain phase hands control back to the host
  a_r7_mode_returns: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fs_ld |=> (cmd_q[1:0] == MODE_NORM) && !wr_lock && out_en);

  // R13: entering sleep from normal darkens the output without waking
  a_r13_sleep_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM && cmd_q[1:0] == MODE_SLEEP) |=> !out_en && !waking);

  // R6: at most one of the busy phases is active
  a_r6_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({waking, cal_ofs_run, cal_gain_run}));

endmodule

// File: tb/test_conv_mode_ctrl.sv
`timescale 1ns/1ps
module test_conv_mode_ctrl;

  localparam int unsigned WAKE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'b00;
  logic [23:0] host_wdata = '0;
  logic        ofs_done = 1'b0;
  logic [23:0] ofs_result = '0;
  logic        gain_done = 1'b0;
  logic [23:0] fs_result = '0;
  logic [15:0] cmd_q, data_q;
  logic [23:0] ofs_q, fs_q;
  logic        out_en, wr_lock, waking, cal_ofs_run, cal_gain_run, cal_ofs_ld, cal_fs_ld;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  conv_mode_ctrl #(.WAKE_CYC(WAKE)) i_conv_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .ofs_done(ofs_done), .ofs_result(ofs_result),
    .gain_done(gain_done), .fs_result(fs_result), .cmd_q(cmd_q), .data_q(data_q),
    .ofs_q(ofs_q), .fs_q(fs_q), .out_en(out_en), .wr_lock(wr_lock), .waking(waking),
    .cal_ofs_run(cal_ofs_run), .cal_gain_run(cal_gain_run),
    .cal_ofs_ld(cal_ofs_ld), .cal_fs_ld(cal_fs_ld)
  );

  // {sel, wdata, exp cmd, exp data, exp ofs, exp fs}, all applied in sleep (R2)
  localparam int NV = 10;
  localparam logic [105:0] VEC [NV] = '{
    {2'd0, 24'h001234, 16'h0002, 16'h1234, 24'h000000, 24'h000000},
    {2'd2, 24'hABCDEF, 16'h0002, 16'h1234, 24'hABCDEF, 24'h000000},
    {2'd3, 24'h123456, 16'h0002, 16'h1234, 24'hABCDEF, 24'h123456},
    {2'd1, 24'h000012, 16'h0002, 16'h0000, 24'hABCDEF, 24'h123456},
    {2'd0, 24'h00BEEF, 16'h0002, 16'hBEEF, 24'hABCDEF, 24'h123456},
    {2'd1, 24'h000022, 16'h0002, 16'hBEEF, 24'h000000, 24'h000000},
    {2'd2, 24'h00F00D, 16'h0002, 16'hBEEF, 24'h00F00D, 24'h000000},
    {2'd3, 24'hFFFFFF, 16'h0002, 16'hBEEF, 24'h00F00D, 24'hFFFFFF},
    {2'd1, 24'h00A50E, 16'hA50E, 16'hBEEF, 24'h00F00D, 24'hFFFFFF},
    {2'd1, 24'h000032, 16'h0002, 16'h0000, 24'h000000, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] sel, input logic [23:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse_ofs(input logic [23:0] r);
    ofs_done = 1'b1; ofs_result = r;
    @(negedge clk);
    ofs_done = 1'b0;
  endtask

  task automatic pulse_gain(input logic [23:0] r);
    gain_done = 1'b1; fs_result = r;
    @(negedge clk);
    gain_done = 1'b0;
  endtask

  task automatic wait_wake(input string req);
    for (int k = 1; k <= WAKE + 1; k++) begin
      @(negedge clk);
      if (k == 1 || k == WAKE) begin
        chk({req, " waking"}, 32'(waking), 32'd1);
        chk({req, " dark"}, 32'(out_en), 32'd0);
      end
      if (k == WAKE + 1) chk({req, " waking end"}, 32'(waking), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", 32'(cmd_q), 32'h0002);
    chk("R1 data", 32'(data_q), 32'h0);
    chk("R1 ofs", 32'(ofs_q), 32'h0);
    chk("R1 fs", 32'(fs_q), 32'h0);
    chk("R1 outs", {29'd0, out_en, wr_lock, waking}, 32'd0);

    // table walk in sleep: R2, R9, R10
    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VEC[i];
      wr(v[105:104], v[103:80]);
      chk("R2/R9/R10 cmd", 32'(cmd_q), 32'(v[79:64]));
      chk("R2/R9 data", 32'(data_q), 32'(v[63:48]));
      chk("R2/R10 ofs", 32'(ofs_q), 32'(v[47:24]));
      chk("R2/R10 fs", 32'(fs_q), 32'(v[23:0]));
      chk("R2 sleep dark", 32'(out_en), 32'd0);
    end

    // R3 wake to normal
    wr(2'd1, 24'h000000);
    chk("R3 before wake", 32'(waking), 32'd0);
    wait_wake("R3");
    chk("R3 normal out_en", 32'(out_en), 32'd1);

    // R12 stray done pulses in normal
    pulse_ofs(24'h111111);
    pulse_gain(24'h222222);
    chk("R12 ofs kept", 32'(ofs_q), 32'h0);
    chk("R12 fs kept", 32'(fs_q), 32'h0);
    chk("R12 no phase", {30'd0, cal_ofs_run, cal_gain_run}, 32'd0);

    // R11 reserved mode
    wr(2'd1, 24'h000003);
    @(negedge clk);
    chk("R11 readback", 32'(cmd_q), 32'h0003);
    chk("R11 out_en", 32'(out_en), 32'd1);
    chk("R11 lock", 32'(wr_lock), 32'd0);

    // R13 normal to sleep directly
    wr(2'd1, 24'h000000);
    wr(2'd1, 24'h000002);
    @(negedge clk);
    chk("R13 dark", 32'(out_en), 32'd0);
    chk("R13 no wake", 32'(waking), 32'd0);
    wr(2'd1, 24'h000000);
    wait_wake("R13 rewake");
    wr(2'd0, 24'h004321);

    // R4..R8 calibration with output isolated
    wr(2'd1, 24'h000001);
    chk("R4 lock", 32'(wr_lock), 32'd1);
    chk("R4 not yet", 32'(cal_ofs_run), 32'd0);
    @(negedge clk);
    chk("R4 ofs phase", 32'(cal_ofs_run), 32'd1);
    chk("R8 isolated", 32'(out_en), 32'd0);
    wr(2'd0, 24'h005555);
    chk("R5 data kept", 32'(data_q), 32'h4321);
    wr(2'd1, 24'h000000);
    chk("R5 cmd kept", 32'(cmd_q), 32'h0001);
    wr(2'd2, 24'h777777);
    chk("R5 ofs kept", 32'(ofs_q), 32'h0);
    pulse_gain(24'h333333);
    chk("R6 gain ignored", 32'(fs_q), 32'h0);
    chk("R6 still ofs", 32'(cal_ofs_run), 32'd1);
    pulse_ofs(24'hFFFFF0);
    chk("R6 ofs capture", 32'(ofs_q), 32'h7FFFF0);
    chk("R6 gain phase", 32'(cal_gain_run), 32'd1);
    pulse_gain(24'h9ABCDE);
    chk("R7 fs capture", 32'(fs_q), 32'h9ABCDE);
    chk("R7 mode back", 32'(cmd_q), 32'h0000);
    chk("R7 unlocked", 32'(wr_lock), 32'd0);
    chk("R7 normal", 32'(out_en), 32'd1);

    // R8 calibration with output connected
    wr(2'd1, 24'h000009);
    @(negedge clk);
    chk("R8 connected", 32'(out_en), 32'd1);
    pulse_ofs(24'h000010);
    chk("R6 ofs positive", 32'(ofs_q), 32'h800010);
    chk("R8 connected gain", 32'(out_en), 32'd1);
    pulse_gain(24'h00FFFF);
    chk("R7 keep other bits", 32'(cmd_q), 32'h0008);

    // R3/R4 sleep straight to calibration
    wr(2'd1, 24'h00000A);
    @(negedge clk);
    chk("R13 sleep dark", 32'(out_en), 32'd0);
    wr(2'd1, 24'h000009);
    chk("R4 lock from sleep", 32'(wr_lock), 32'd1);
    wait_wake("R3 to cal");
    chk("R4 cal after wake", 32'(cal_ofs_run), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule